// File: doc/BRIEF.md
# Dual-Channel Maskable Interrupt Combiner

This block merges the interrupt requests of two disk channels onto one shared, level-sensitive interrupt line. Each channel's request level is captured into a pending bit that follows the request and never latches. Software can set a block bit for each channel, and the shared line is asserted while at least one channel has its pending bit set and its block bit clear.

Software reaches the block through a byte-wide register port with a small address select. Address 0 is the mode register, which holds the pending and block bits. Addresses 1 and 2 hold one free-use timing byte per channel. Reads return the addressed byte in the same cycle. Writes take effect on the next clock edge.

Top module: `chan_irq_combiner`

## Requirements
- R1: Synchronous active-high reset clears both block bits, both pending bits and both timing bytes, and deasserts `irq_out`. Every address then reads 0x00.
- R2: Mode-register bit 2 (channel 0) and bit 3 (channel 1) show the level of `chan_req[0]` and `chan_req[1]` as sampled at the most recent clock edge. A pending bit clears when its request falls and does not stay set.
- R3: A write to address 0 loads `reg_wdata[4]` into the channel 0 block bit (mode bit 4) and `reg_wdata[5]` into the channel 1 block bit (mode bit 5). The write leaves the pending bits unchanged.
- R4: `irq_out` is a register that takes the value (pending0 AND NOT block0) OR (pending1 AND NOT block1) at each clock edge. It therefore changes one edge after the pending or block bit that caused the change.
- R5: Address 1 holds the channel 0 timing byte and address 2 holds the channel 1 timing byte. Each reads back exactly what was last written to it. A write to any other address leaves both bytes unchanged.
- R6: Mode-register bits 7:6 and 1:0 always read zero. Address 3 reads 0x00, and a write to address 3 changes no state.
- R7: `reg_rdata` shows the addressed register combinationally, in the same cycle as `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | 2 | Per-channel interrupt request level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 timing ch0, 2 timing ch1, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_out | output | 1 | Combined interrupt line |

## Verification
A wrong pending or block bit shows up at once in a read of the mode register. It also reaches `irq_out` exactly one edge later, so the bench checks the line both before and after that edge.

A block bit that a write fails to load, or that a write corrupts, shows up as an interrupt that is wrongly passed or wrongly suppressed. This is visible two edges after the write.

Timing bytes can only be seen through reads. For that reason they are read back after writes to the mode register and to the unused address.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
    localparam int NUM_CH   = 2;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int PEND_LSB = 2;
    localparam int BLK_LSB  = 4;
    localparam int TIM_BASE = 1;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_MODE = 2'd0,
        ADDR_TIM0 = 2'd1,
        ADDR_TIM1 = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [NUM_CH-1:0] blk;
        logic [NUM_CH-1:0] pend;
    } mode_t;

    function automatic logic [DATA_W-1:0] mode_pack(input mode_t m);
        logic [DATA_W-1:0] b;
        b = '0;
        b[PEND_LSB +: NUM_CH] = m.pend;
        b[BLK_LSB  +: NUM_CH] = m.blk;
        return b;
    endfunction

    function automatic logic [ADDR_W-1:0] tim_addr(input int ch);
        return ADDR_W'(TIM_BASE + ch);
    endfunction
endpackage

// File: rtl/chan_irq_regs.sv
module chan_irq_regs
    import chan_irq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CH-1:0]             req,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output mode_t                         mode,
    output logic [NUM_CH-1:0][DATA_W-1:0] tim
);
    logic mode_we;
    assign mode_we = wr && (addr == ADDR_MODE);

    // Pending follows the request level; block is written by software only.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else begin
            mode.pend <= req;
            if (mode_we) mode.blk <= wdata[BLK_LSB +: NUM_CH];
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_tim
        always_ff @(posedge clk) begin
            if (rst)
                tim[i] <= '0;
            else if (wr && (addr == tim_addr(i)))
                tim[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_MODE)
            rdata = mode_pack(mode);
        for (int i = 0; i < NUM_CH; i++)
            if (addr == tim_addr(i))
                rdata = tim[i];
    end
endmodule

// File: rtl/chan_irq_merge.sv
module chan_irq_merge
    import chan_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    output logic  irq
);
    logic [NUM_CH-1:0] gated;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_gate
        assign gated[i] = mode.pend[i] & ~mode.blk[i];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |gated;
    end
endmodule

// File: rtl/chan_irq_combiner.sv
module chan_irq_combiner
    import chan_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    mode_t                         mode_q;
    logic [NUM_CH-1:0][DATA_W-1:0] tim_q;

    chan_irq_regs i_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (chan_req),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .mode  (mode_q),
        .tim   (tim_q)
    );

    chan_irq_merge i_merge (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_q),
        .irq  (irq_out)
    );
endmodule

// File: rtl/chan_irq_checker.sv
module chan_irq_checker
    import chan_irq_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_CH-1:0]             chan_req,
    input logic                          reg_wr,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [DATA_W-1:0]             reg_wdata,
    input logic [DATA_W-1:0]             reg_rdata,
    input logic                          irq_out,
    input mode_t                         mode_q,
    input logic [NUM_CH-1:0][DATA_W-1:0] tim_q
);
    assert_pend_follows_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> mode_q.pend == $past(chan_req));

    assert_blk_load_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_MODE) |=> mode_q.blk == $past(reg_wdata[BLK_LSB +: NUM_CH]));

    assert_blk_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == ADDR_MODE) |=> $stable(mode_q.blk));

    assert_irq_combine_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_out == $past(|(mode_q.pend & ~mode_q.blk)));

    assert_tim0_write_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_TIM0) |=> tim_q[0] == $past(reg_wdata));

    assert_tim_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && (reg_addr == ADDR_TIM0 || reg_addr == ADDR_TIM1)) |=> $stable(tim_q));

    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_MODE) |-> (reg_rdata[7:6] == 2'b00 && reg_rdata[1:0] == 2'b00));

    assert_none_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_NONE) |-> reg_rdata == '0);
endmodule

bind chan_irq_combiner chan_irq_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .chan_req  (chan_req),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .mode_q    (mode_q),
    .tim_q     (tim_q)
);

// File: tb/test_chan_irq_combiner.sv
`timescale 1ns/1ps
module test_chan_irq_combiner;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] chan_req = 2'b00;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    chan_irq_combiner i_chan_irq_combiner (
        .clk       (clk),
        .rst       (rst),
        .chan_req  (chan_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    // {req[1:0], wr, wdata[7:0], exp_mode[7:0], exp_irq}
    localparam int NVEC = 12;
    localparam logic [19:0] VEC [NVEC] = '{
        {2'b00, 1'b0, 8'h00, 8'h00, 1'b0},
        {2'b01, 1'b0, 8'h00, 8'h04, 1'b1},
        {2'b10, 1'b0, 8'h00, 8'h08, 1'b1},
        {2'b11, 1'b1, 8'h10, 8'h1C, 1'b1},
        {2'b01, 1'b0, 8'h00, 8'h14, 1'b0},
        {2'b01, 1'b1, 8'hFF, 8'h34, 1'b0},
        {2'b11, 1'b0, 8'h00, 8'h3C, 1'b0},
        {2'b11, 1'b1, 8'h20, 8'h2C, 1'b1},
        {2'b10, 1'b0, 8'h00, 8'h28, 1'b0},
        {2'b00, 1'b1, 8'h00, 8'h00, 1'b0},
        {2'b11, 1'b1, 8'hCF, 8'h0C, 1'b1},
        {2'b00, 1'b0, 8'h00, 8'h00, 1'b0}
    };

    task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", rq, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string rq, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(rq, reg_rdata, exp);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, "R1 mode", 8'h00);
        rd(2'd1, "R1 tim0", 8'h00);
        rd(2'd2, "R1 tim1", 8'h00);
        check("R1 irq", {7'b0, irq_out}, 8'h00);

        // Vector walk: R2 pending, R3 block, R4 combine, R6 unused bits
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            chan_req  = VEC[k][19:18];
            reg_wr    = VEC[k][17];
            reg_addr  = 2'd0;
            reg_wdata = VEC[k][16:9];
            @(negedge clk);
            reg_wr = 1'b0;
            @(negedge clk);
            rd(2'd0, "R2 R3 R6 mode", VEC[k][8:1]);
            check("R4 irq", {7'b0, irq_out}, {7'b0, VEC[k][0]});
        end

        // R4 latency: one edge after pending rises, irq still low; next edge high
        @(negedge clk);
        chan_req = 2'b01;
        @(negedge clk);
        rd(2'd0, "R2 R7 pend visible", 8'h04);
        check("R4 irq not yet", {7'b0, irq_out}, 8'h00);
        @(negedge clk);
        check("R4 irq after edge", {7'b0, irq_out}, 8'h01);
        // R2 no latching: drop request
        chan_req = 2'b00;
        @(negedge clk);
        rd(2'd0, "R2 pend clears", 8'h00);
        @(negedge clk);
        check("R4 irq drops", {7'b0, irq_out}, 8'h00);

        // R5 timing bytes
        wr_reg(2'd1, 8'hA5);
        wr_reg(2'd2, 8'h3C);
        rd(2'd1, "R5 tim0", 8'hA5);
        rd(2'd2, "R5 tim1", 8'h3C);
        wr_reg(2'd0, 8'hFF);
        rd(2'd1, "R5 tim0 after mode write", 8'hA5);
        rd(2'd2, "R5 tim1 after mode write", 8'h3C);
        rd(2'd0, "R3 mode after FF", 8'h30);
        // R6 address 3
        wr_reg(2'd3, 8'h77);
        rd(2'd3, "R6 addr3 reads zero", 8'h00);
        rd(2'd1, "R6 tim0 after addr3 write", 8'hA5);
        rd(2'd2, "R6 tim1 after addr3 write", 8'h3C);
        rd(2'd0, "R6 mode after addr3 write", 8'h30);

        // R1 mid-run reset
        @(negedge clk);
        chan_req = 2'b11;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(2'd0, "R1 mode in reset", 8'h00);
        rd(2'd1, "R1 tim0 in reset", 8'h00);
        rd(2'd2, "R1 tim1 in reset", 8'h00);
        check("R1 irq in reset", {7'b0, irq_out}, 8'h00);
        rst = 1'b0;
        chan_req = 2'b00;
        @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule